// File: doc/BRIEF.md
# Log-Domain Shift-Add Dot-Product Array

This block is a row of parallel processing elements that compute the dot products of a convolution laid out as a matrix multiplication. No hardware multiplier is used. Every weight arrives as a 6-bit code: a sign and an index into a weight level set. Large magnitudes in that set sit on quarter-octave (fractional log2) steps, and small magnitudes sit on whole-octave steps. Every activation arrives as an exponent code. A product is therefore a table read, one right shift and one signed add.

One activation code is broadcast to all elements on each cycle, and each element receives its own weight code on its own lane. So each element builds a different output value from the same activation stream. Each element has a three-stage pipeline: weight decode, then shift, then accumulate. It takes one operand pair per cycle. A start flag on an operand pair begins a new dot product. A last flag raises a one-cycle valid pulse when the finished sum appears. A clear input empties every accumulator at once.

Top module: `logmac_array`

## Requirements
- R1: A weight code holds the sign in bit 5 (1 = negative) and the level index in bits 4:0. Index 0 is a zero weight: its product is 0 whatever the sign and the activation.
- R2: Activation code 0 means a zero activation and gives a product of 0. A nonzero code c means an activation of 2^-c.
- R3: For index i from 1 to 16, the weight magnitude is 2^-((i-1)/4) (fractional exponent). The integer shift is floor((i-1)/4). The constant is K[(i-1) mod 4], with K = 4096, 3444, 2896, 2435 (unsigned, 12 fractional bits). The product magnitude is K >> (c + shift).
- R4: For index i from 17 to 31, the weight magnitude is 2^-(i-13) (integer exponent). The constant is 4096 and the product magnitude is 4096 >> (c + i - 13).
- R5: Bits shifted out are discarded (truncation toward zero of the magnitude). A total shift of 13 or more gives 0.
- R6: A negative weight subtracts the product magnitude from the sum, and a positive weight adds it.
- R7: A pair flagged as first loads the accumulator with its own product. Valid pairs without the flag add to the running sum.
- R8: A pair sampled at clock edge k is first visible in the sum after edge k+2. Pairs may be presented on every cycle with no gaps.
- R9: out_valid is high for exactly the one cycle after edge k+2 when the pair sampled at edge k carried the last flag. At all other times it is low.
- R10: The accumulator is ACC_W bits, signed. It saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1) and never wraps. Later pairs move it back from the limit.
- R11: clr is synchronous. At the edge where it is sampled, every sum becomes 0 and out_valid is low. A product reaching the accumulator at that edge is dropped.
- R12: After reset every sum is 0 and out_valid is low.
- R13: Element p uses weight lane bits 6p+5..6p and drives sum bits ACC_W*p+ACC_W-1..ACC_W*p. All elements share the activation code and the control flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all sums |
| in_valid | input | 1 | Operand pair present this cycle |
| in_first | input | 1 | Pair starts a new dot product |
| in_last | input | 1 | Pair ends the dot product |
| w_codes | input | 6*NUM_PE | One weight code per element |
| a_code | input | A_BITS | Shared activation exponent code |
| acc_out | output | ACC_W*NUM_PE | Signed sum of each element |
| out_valid | output | 1 | Finished-sum pulse |

## Verification
Two situations are the hardest to reach from the ports: a clear that lands in the same edge as a product entering the accumulator, and the saturation limits. For the first, the bench raises clr exactly two edges after a flagged pair, so the pair is in the accumulate stage when the clear hits. The limits would need thousands of maximal products at the default width. The bench therefore builds the array with a 16-bit accumulator, chains twenty maximal positive and negative products to both limits, and then steps back from each limit. Every weight code is swept against every activation code of a 4-bit configuration, with a different code on each lane.

// File: rtl/logmac_pkg.sv
package logmac_pkg;

    localparam int IDX_W       = 5;
    localparam int W_BITS      = IDX_W + 1;
    localparam int FRAC_BITS   = 12;
    localparam int CONST_W     = FRAC_BITS + 1;
    localparam int FRAC_LEVELS = 16;
    localparam int STEP_LOG2   = 2;
    localparam int STEPS       = 1 << STEP_LOG2;
    localparam int INT_EXP_W   = 5;

    // integer part of the weight exponent for a level index
    function automatic logic [INT_EXP_W-1:0] idx_int_exp(input logic [IDX_W-1:0] idx);
        int i;
        i = int'(idx);
        if (i == 0) return '0;
        if (i <= FRAC_LEVELS) return INT_EXP_W'((i - 1) >> STEP_LOG2);
        return INT_EXP_W'((FRAC_LEVELS >> STEP_LOG2) + (i - FRAC_LEVELS - 1));
    endfunction

    // stored 2^-fraction constant, 12 fractional bits
    function automatic logic [CONST_W-1:0] idx_const(input logic [IDX_W-1:0] idx);
        int i;
        i = int'(idx);
        if (i == 0 || i > FRAC_LEVELS) return CONST_W'(1 << FRAC_BITS);
        case ((i - 1) & (STEPS - 1))
            0:       return CONST_W'(1 << FRAC_BITS);
            1:       return CONST_W'(3444);
            2:       return CONST_W'(2896);
            default: return CONST_W'(2435);
        endcase
    endfunction

endpackage

// File: rtl/logmac_wdecode.sv
module logmac_wdecode
    import logmac_pkg::*;
(
    input  logic [W_BITS-1:0]    code,
    output logic                 zero_w,
    output logic                 neg,
    output logic [INT_EXP_W-1:0] int_exp,
    output logic [CONST_W-1:0]   konst
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = code[IDX_W-1:0];
        neg     = code[W_BITS-1];
        zero_w  = (idx == '0);
        int_exp = idx_int_exp(idx);
        konst   = idx_const(idx);
    end
endmodule

// File: rtl/logmac_satadd.sv
module logmac_satadd #(
    parameter int ACC_W  = 24,
    parameter int PROD_W = 14
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic signed [PROD_W-1:0] addend,
    input  logic                     load,
    output logic signed [ACC_W-1:0]  result
);
    logic signed [ACC_W:0] base;
    logic signed [ACC_W:0] sum;

    always_comb begin
        base = load ? '0 : (ACC_W+1)'(acc_in);
        sum  = base + (ACC_W+1)'(addend);
        if (sum[ACC_W] != sum[ACC_W-1])
            result = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        else
            result = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/logmac_pe.sv
module logmac_pe
    import logmac_pkg::*;
#(
    parameter int A_BITS = 6,
    parameter int ACC_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [W_BITS-1:0]       w_code,
    input  logic [A_BITS-1:0]       a_code,
    output logic signed [ACC_W-1:0] acc,
    output logic                    done
);
    localparam int SH_W   = A_BITS + 2;
    localparam int PROD_W = CONST_W + 1;

    typedef struct packed {
        logic                v;
        logic                first;
        logic                last;
        logic                kill;
        logic                neg;
        logic [SH_W-1:0]     sh;
        logic [CONST_W-1:0]  k;
    } dec_st_t;

    typedef struct packed {
        logic                     v;
        logic                     first;
        logic                     last;
        logic signed [PROD_W-1:0] prod;
    } shf_st_t;

    typedef struct packed {
        dec_st_t                 s1;
        shf_st_t                 s2;
        logic signed [ACC_W-1:0] acc;
        logic                    done;
    } pe_st_t;

    pe_st_t st_d, st_q;

    logic                    w_zero;
    logic                    w_neg;
    logic [INT_EXP_W-1:0]    w_int;
    logic [CONST_W-1:0]      w_k;
    logic signed [ACC_W-1:0] sat_res;
    logic [CONST_W-1:0]      mag;

    logmac_wdecode u_dec (
        .code    (w_code),
        .zero_w  (w_zero),
        .neg     (w_neg),
        .int_exp (w_int),
        .konst   (w_k)
    );

    logmac_satadd #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_sat (
        .acc_in (st_q.acc),
        .addend (st_q.s2.prod),
        .load   (st_q.s2.first),
        .result (sat_res)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: table decode and exponent sum
        st_d.s1.v     = in_valid;
        st_d.s1.first = in_valid & in_first;
        st_d.s1.last  = in_valid & in_last;
        st_d.s1.kill  = w_zero | (a_code == '0);
        st_d.s1.neg   = w_neg;
        st_d.s1.sh    = SH_W'(a_code) + SH_W'(w_int);
        st_d.s1.k     = w_k;

        // stage 2: truncating shift and sign
        if (st_q.s1.kill || (st_q.s1.sh >= SH_W'(CONST_W)))
            mag = '0;
        else
            mag = st_q.s1.k >> st_q.s1.sh;
        st_d.s2.v     = st_q.s1.v;
        st_d.s2.first = st_q.s1.first;
        st_d.s2.last  = st_q.s1.last;
        st_d.s2.prod  = st_q.s1.neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

        // stage 3: saturating accumulate
        st_d.done = st_q.s2.v & st_q.s2.last;
        if (st_q.s2.v) st_d.acc = sat_res;
        if (clr) begin
            st_d.acc  = '0;
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc  = st_q.acc;
    assign done = st_q.done;

    assert_zero_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.v && st_q.s1.kill) |=> (st_q.s2.prod == '0))
        else $error("zero operand gave nonzero product");

    assert_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.v && (st_q.s1.sh >= SH_W'(CONST_W))) |=> (st_q.s2.prod == '0))
        else $error("shift past constant width gave nonzero product");

    assert_first_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2.v && st_q.s2.first && !clr) |=> (st_q.acc == $past(st_q.s2.prod)))
        else $error("first pair did not load its own product");

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2.v && !st_q.s2.first && !clr && (st_q.s2.prod > 0))
        |=> ($signed(st_q.acc) >= $signed($past(st_q.acc))))
        else $error("positive addend lowered the sum");

    assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2.v && st_q.s2.last && !clr) |=> st_q.done)
        else $error("missing completion pulse");

    assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.s2.v && st_q.s2.last) |=> !st_q.done)
        else $error("completion pulse without last pair");

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((st_q.acc == '0) && !st_q.done))
        else $error("clear did not empty the sum");
endmodule

// File: rtl/logmac_array.sv
module logmac_array
    import logmac_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int A_BITS = 6,
    parameter int ACC_W  = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      in_valid,
    input  logic                      in_first,
    input  logic                      in_last,
    input  logic [NUM_PE*W_BITS-1:0]  w_codes,
    input  logic [A_BITS-1:0]         a_code,
    output logic [NUM_PE*ACC_W-1:0]   acc_out,
    output logic                      out_valid
);
    logic [NUM_PE-1:0] done_vec;

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        logic signed [ACC_W-1:0] pe_acc;

        logmac_pe #(.A_BITS(A_BITS), .ACC_W(ACC_W)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .in_valid (in_valid),
            .in_first (in_first),
            .in_last  (in_last),
            .w_code   (w_codes[p*W_BITS +: W_BITS]),
            .a_code   (a_code),
            .acc      (pe_acc),
            .done     (done_vec[p])
        );

        assign acc_out[p*ACC_W +: ACC_W] = pe_acc;
    end

    assign out_valid = done_vec[0];

    assert_lockstep_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done_vec == {NUM_PE{done_vec[0]}})
        else $error("elements disagree on completion");

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid)
        else $error("completion pulse right after reset");
endmodule

// File: tb/logmac_array_test.sv
module logmac_array_test;
    localparam int NPE = 4;
    localparam int AB  = 4;
    localparam int AW  = 16;
    localparam int WB  = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               clr;
    logic               in_valid;
    logic               in_first;
    logic               in_last;
    logic [NPE*WB-1:0]  w_codes;
    logic [AB-1:0]      a_code;
    logic [NPE*AW-1:0]  acc_out;
    logic               out_valid;

    int n_checks = 0;
    int n_fail   = 0;

    logmac_array #(.NUM_PE(NPE), .A_BITS(AB), .ACC_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_first(in_first), .in_last(in_last), .w_codes(w_codes),
        .a_code(a_code), .acc_out(acc_out), .out_valid(out_valid)
    );

    // product from the requirements R1..R6
    function automatic int ref_prod(int w, int a);
        int idx, ip, k, s, m;
        int kt[4] = '{4096, 3444, 2896, 2435};
        idx = w & 31;
        if (idx == 0 || a == 0) return 0;
        if (idx <= 16) begin
            ip = (idx - 1) / 4;
            k  = kt[(idx - 1) % 4];
        end else begin
            ip = idx - 13;
            k  = 4096;
        end
        s = a + ip;
        m = (s >= 13) ? 0 : (k / (1 << s));
        return (w >= 32) ? -m : m;
    endfunction

    function automatic int sat(int v);
        int hi, lo;
        hi = (1 << (AW - 1)) - 1;
        lo = -(1 << (AW - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic string tag_of(int w, int a);
        int idx;
        idx = w & 31;
        if (idx == 0) return "R1";
        if (a == 0) return "R2";
        if (a + ((idx <= 16) ? (idx - 1) / 4 : idx - 13) >= 13) return "R5";
        if (w >= 32) return "R6";
        if (idx <= 16) return "R3";
        return "R4";
    endfunction

    function automatic int lane(int p);
        logic signed [AW-1:0] v;
        v = acc_out[p*AW +: AW];
        return int'(v);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put(input int wc[NPE], input int a, input bit f, input bit l);
        for (int p = 0; p < NPE; p++) w_codes[p*WB +: WB] = WB'(wc[p]);
        a_code   = AB'(a);
        in_valid = 1'b1;
        in_first = f;
        in_last  = l;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int wc[NPE];
        int run[6][NPE];
        int pw[6][NPE];
        int pa[6];
        int e;

        rst_n = 1'b0; clr = 1'b0; w_codes = '0; a_code = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NPE; p++) check("R12", lane(p), 0, "sum after reset");
        check("R12", int'(out_valid), 0, "valid after reset");

        // exhaustive sweep of weight codes against activation codes (R1..R6, R13)
        for (int w = 0; w < 64; w++) begin
            for (int a = 0; a < 16; a++) begin
                for (int p = 0; p < NPE; p++) wc[p] = (w + 16 * p) % 64;
                @(negedge clk); put(wc, a, 1'b1, 1'b1);
                @(negedge clk); idle();
                @(negedge clk);
                @(negedge clk);
                for (int p = 0; p < NPE; p++)
                    check(tag_of(wc[p], a), lane(p), ref_prod(wc[p], a), "single product R13");
                check("R9", int'(out_valid), 1, "valid after single pair");
            end
        end

        // back-to-back stream: latency and accumulation (R7, R8, R9)
        pulse_clr();
        for (int i = 0; i < 6; i++) begin
            pa[i] = (i * 5 + 3) % 16;
            for (int p = 0; p < NPE; p++) begin
                pw[i][p] = (i * 11 + p * 7 + 1) % 64;
                e = ref_prod(pw[i][p], pa[i]);
                run[i][p] = (i == 0) ? e : sat(run[i-1][p] + e);
            end
        end
        @(negedge clk); put(pw[0], pa[0], 1'b1, 1'b0);
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            for (int p = 0; p < NPE; p++) begin
                e = (j >= 2) ? run[(j - 2 > 5) ? 5 : j - 2][p] : 0;
                check("R8", lane(p), e, "streamed partial sum");
            end
            check("R9", int'(out_valid), (j == 7) ? 1 : 0, "valid timing in stream");
            if (j + 1 < 6) put(pw[j+1], pa[j+1], 1'b0, (j + 1 == 5));
            else idle();
        end

        // continue without first flag, then restart with first flag (R7)
        for (int p = 0; p < NPE; p++) wc[p] = 1 + p;
        @(negedge clk); put(wc, 2, 1'b0, 1'b1);
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk);
        for (int p = 0; p < NPE; p++)
            check("R7", lane(p), sat(run[5][p] + ref_prod(wc[p], 2)), "add without first");
        @(negedge clk); put(wc, 3, 1'b1, 1'b1);
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk);
        for (int p = 0; p < NPE; p++)
            check("R7", lane(p), ref_prod(wc[p], 3), "first reloads");

        // saturation at both limits (R10)
        for (int p = 0; p < NPE; p++) wc[p] = (p % 2 == 0) ? 1 : 33;
        @(negedge clk); put(wc, 1, 1'b1, 1'b0);
        for (int i = 1; i < 20; i++) begin
            @(negedge clk); put(wc, 1, 1'b0, (i == 19));
        end
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        for (int p = 0; p < NPE; p++)
            check("R10", lane(p), (p % 2 == 0) ? 32767 : -32768, "saturated sum");
        for (int p = 0; p < NPE; p++) wc[p] = (p % 2 == 0) ? 33 : 1;
        @(negedge clk); put(wc, 1, 1'b0, 1'b1);
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk);
        for (int p = 0; p < NPE; p++)
            check("R10", lane(p), (p % 2 == 0) ? 30719 : -30720, "step back from limit");

        // plain clear of a nonzero sum (R11)
        pulse_clr();
        for (int p = 0; p < NPE; p++) check("R11", lane(p), 0, "sum after clear");

        // clear colliding with a product in the accumulate stage (R11)
        for (int p = 0; p < NPE; p++) wc[p] = 17 + p;
        @(negedge clk); put(wc, 1, 1'b1, 1'b1);
        @(negedge clk); idle();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        for (int p = 0; p < NPE; p++) check("R11", lane(p), 0, "product dropped by clear");
        check("R11", int'(out_valid), 0, "valid suppressed by clear");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule